// File: doc/BRIEF.md
# Interrupt Countdown Timer

This block is a programmable down-counter on a 32-bit register bus, used as a per-core tick source. Software chooses a clock divider, programs a timer entry with a vector, a mask bit and a reload mode, and then writes an initial count. The counter is loaded from that value and decrements once for every divided clock period. When it passes from one to zero it raises an interrupt request that carries the programmed vector, unless the entry is masked or the global software enable is off. In one-shot mode the counter then stays at zero. In periodic mode it reloads from the initial count on the same tick.

A pending request stays asserted until software writes any value to the end-of-interrupt register. Expiries that occur while a request is already pending are not queued. A third mode code, for timestamp deadlines, is accepted and read back, but in that mode the counter holds its value.

The register bus is a plain single-cycle write port with a combinational read path. Every write is accepted in the cycle it is presented, so the bus has no back-pressure. Read data follows `bus_addr` in the same cycle, whether or not `bus_valid` is high.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset the current count reads 0, the divide register reads 0, the enable register reads 0, the timer entry reads 0x0001_0000 (masked, one-shot, vector 0), and `irq_req` is low.
- R2: A write to the initial-count register (offset 0x380) stores the value, which reads back. The same write copies the value into the current counter (offset 0x390) at once, even while a countdown is in progress. Writing zero stops the timer.
- R3: The divide code sits in bits 2:0 of offset 0x3E0. Code c in 0..6 divides by 2^(c+1), so code 3 divides by 16; code 7 divides by 1. The first decrement lands DIV clock edges after the edge of the initial-count write, and each later decrement lands DIV edges after the one before.
- R4: In one-shot mode (mode bits 18:17 of the timer entry at 0x320 equal 00), the counter stays at zero after it expires.
- R5: In periodic mode (mode 01), on the tick where the counter would reach zero it reloads the initial count instead.
- R6: An expiry with the mask clear and the enable set raises `irq_req`. `irq_vector` then presents the entry's vector (bits 7:0 of 0x320) as it stood at expiry, and bit 12 of the timer entry reads 1.
- R7: If mask bit 16 of the timer entry is set, or enable bit 8 of the register at 0x0F0 is clear, an expiry raises no request, but the counter still updates normally. Bits 7:0 of 0x0F0 hold a read/write vector.
- R8: A write of any value to offset 0x0B0 clears the pending request. Expiries while pending are not queued, so after one such write the request stays low until a new expiry. If an unmasked expiry lands in the same cycle as the write, the request stays set.
- R9: In mode 10 (deadline) and in mode 11, the counter holds its value.
- R10: Writes to the current count and to bit 12 of the timer entry have no effect. Unused bits and unmapped offsets read as zero, and the register at 0x0B0 reads as zero.
- R11: An initial count of 0xFFFF_FFFF is legal. After n ticks the current count reads 0xFFFF_FFFF − n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access strobe; a write is accepted in the same cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register at `bus_addr`, combinational |
| irq_req | output | 1 | Interrupt request, held until end-of-interrupt |
| irq_vector | output | 8 | Vector latched at the expiry that raised the request |

## Verification
The bound checker checks these properties on every cycle:
- The counter only holds, steps down by one, or takes the initial count.
- A counter at zero stays at zero unless it is loaded.
- The deadline modes freeze the count.
- A request rises only after an unmasked, enabled expiry.
- An end-of-interrupt write without a coincident expiry drops the request.

The bench scenarios show the rest:
- the exact tick spacing for several divide codes;
- the periodic reload value;
- an end-of-interrupt write colliding with an expiry;
- the absence of queued expiries;
- read-only and reserved bits;
- the elapsed-tick arithmetic from the maximum count.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

  localparam int DIV_CODE_W = 3;
  localparam int PRE_W      = (1 << DIV_CODE_W) - 1;
  localparam int VEC_W      = 8;

  localparam int NREG    = 6;
  localparam int IX_EOI  = 0;
  localparam int IX_SPV  = 1;
  localparam int IX_LVT  = 2;
  localparam int IX_INIT = 3;
  localparam int IX_CUR  = 4;
  localparam int IX_DIV  = 5;

  localparam logic [11:0] REG_OFF [NREG] = '{
    12'h0B0, 12'h0F0, 12'h320, 12'h380, 12'h390, 12'h3E0
  };

  localparam int ENT_PEND_BIT = 12;
  localparam int ENT_MASK_BIT = 16;
  localparam int ENT_MODE_LO  = 17;
  localparam int SPV_EN_BIT   = 8;

  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'b00,
    MODE_PERIODIC = 2'b01,
    MODE_DEADLINE = 2'b10,
    MODE_RSVD     = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    logic [VEC_W-1:0] vec;
    logic             mask;
    tmr_mode_e        mode;
  } ent_cfg_t;

  function automatic logic [PRE_W-1:0] div_mask(input logic [DIV_CODE_W-1:0] code);
    logic [PRE_W:0] full;
    if (code == '1) return '0;
    full = (PRE_W+1)'(1) << (code + 1'b1);
    return PRE_W'(full - 1'b1);
  endfunction

endpackage

// File: rtl/itmr_prescaler.sv
module itmr_prescaler
  import itmr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  restart,
  input  logic                  run,
  input  logic [DIV_CODE_W-1:0] div_code,
  output logic                  tick
);

  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] limit;

  assign limit = div_mask(div_code);
  assign tick  = run && !restart && (phase_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)       phase_q <= '0;
    else if (restart) phase_q <= '0;
    else if (run)     phase_q <= tick ? '0 : phase_q + 1'b1;
  end

endmodule

// File: rtl/itmr_counter.sv
module itmr_counter
  import itmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             tick,
  input  tmr_mode_e        mode,
  output logic [CNT_W-1:0] count,
  output logic             active,
  output logic             expire
);

  logic at_one;

  assign at_one = (count == CNT_W'(1));
  assign active = (count != '0) &&
                  ((mode == MODE_ONESHOT) || (mode == MODE_PERIODIC));
  assign expire = tick && at_one;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (tick) begin
      if (at_one) count <= (mode == MODE_PERIODIC) ? reload_val : '0;
      else        count <= count - 1'b1;
    end
  end

endmodule

// File: rtl/itmr_irq_ctrl.sv
module itmr_irq_ctrl
  import itmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expire,
  input  logic             mask,
  input  logic             sw_en,
  input  logic [VEC_W-1:0] vec,
  input  logic             eoi,
  output logic             pending,
  output logic [VEC_W-1:0] vec_q
);

  logic fire;

  assign fire = expire && !mask && sw_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      vec_q   <= '0;
    end else if (fire) begin
      pending <= 1'b1;
      vec_q   <= vec;
    end else if (eoi) begin
      pending <= 1'b0;
    end
  end

endmodule

// File: rtl/itmr_regfile.sv
module itmr_regfile
  import itmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wr_data,
  input  logic [CNT_W-1:0]      cur_count,
  input  logic                  pending,
  output ent_cfg_t              ent,
  output logic                  sw_en,
  output logic [VEC_W-1:0]      sw_vec,
  output logic [CNT_W-1:0]      init_q,
  output logic [DIV_CODE_W-1:0] div_code,
  output logic                  init_wr,
  output logic                  eoi_wr,
  output logic [31:0]           rd_data
);

  logic [NREG-1:0] hit;
  logic [NREG-1:0] wr_hit;

  for (genvar i = 0; i < NREG; i++) begin : g_dec
    assign hit[i]    = (addr == ADDR_W'(REG_OFF[i]));
    assign wr_hit[i] = wr_en && hit[i];
  end

  assign init_wr = wr_hit[IX_INIT];
  assign eoi_wr  = wr_hit[IX_EOI];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent      <= '{vec: '0, mask: 1'b1, mode: MODE_ONESHOT};
      sw_en    <= 1'b0;
      sw_vec   <= '0;
      init_q   <= '0;
      div_code <= '0;
    end else begin
      if (wr_hit[IX_SPV]) begin
        sw_en  <= wr_data[SPV_EN_BIT];
        sw_vec <= wr_data[VEC_W-1:0];
      end
      if (wr_hit[IX_LVT]) begin
        ent.vec  <= wr_data[VEC_W-1:0];
        ent.mask <= wr_data[ENT_MASK_BIT];
        ent.mode <= tmr_mode_e'(wr_data[ENT_MODE_LO+1:ENT_MODE_LO]);
      end
      if (wr_hit[IX_INIT]) init_q   <= wr_data[CNT_W-1:0];
      if (wr_hit[IX_DIV])  div_code <= wr_data[DIV_CODE_W-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (hit[IX_SPV]) begin
      rd_data[SPV_EN_BIT]  = sw_en;
      rd_data[VEC_W-1:0]   = sw_vec;
    end
    if (hit[IX_LVT]) begin
      rd_data[VEC_W-1:0]                   = ent.vec;
      rd_data[ENT_PEND_BIT]                = pending;
      rd_data[ENT_MASK_BIT]                = ent.mask;
      rd_data[ENT_MODE_LO+1:ENT_MODE_LO]   = ent.mode;
    end
    if (hit[IX_INIT]) rd_data[CNT_W-1:0]      = init_q;
    if (hit[IX_CUR])  rd_data[CNT_W-1:0]      = cur_count;
    if (hit[IX_DIV])  rd_data[DIV_CODE_W-1:0] = div_code;
  end

endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
  import itmr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vector
);

  ent_cfg_t              ent;
  logic                  sw_en;
  logic [VEC_W-1:0]      sw_vec;
  logic [CNT_W-1:0]      init_q;
  logic [DIV_CODE_W-1:0] div_code;
  logic                  init_wr;
  logic                  eoi_wr;
  logic [CNT_W-1:0]      cur_count;
  logic                  active;
  logic                  expire;
  logic                  tick;
  logic                  pending;
  logic                  wr_en;

  assign wr_en = bus_valid && bus_write;

  itmr_regfile #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (bus_addr),
    .wr_data   (bus_wdata),
    .cur_count (cur_count),
    .pending   (pending),
    .ent       (ent),
    .sw_en     (sw_en),
    .sw_vec    (sw_vec),
    .init_q    (init_q),
    .div_code  (div_code),
    .init_wr   (init_wr),
    .eoi_wr    (eoi_wr),
    .rd_data   (bus_rdata)
  );

  itmr_prescaler pre_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (init_wr),
    .run      (active),
    .div_code (div_code),
    .tick     (tick)
  );

  itmr_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (init_wr),
    .load_val   (bus_wdata[CNT_W-1:0]),
    .reload_val (init_q),
    .tick       (tick),
    .mode       (ent.mode),
    .count      (cur_count),
    .active     (active),
    .expire     (expire)
  );

  itmr_irq_ctrl irq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .expire  (expire),
    .mask    (ent.mask),
    .sw_en   (sw_en),
    .vec     (ent.vec),
    .eoi     (eoi_wr),
    .pending (pending),
    .vec_q   (irq_vector)
  );

  assign irq_req = pending;

endmodule

// File: rtl/itmr_chk.sv
module itmr_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] init_q,
  input logic             init_wr,
  input logic             expire,
  input logic             eoi_wr,
  input logic             irq_req,
  input logic             mask,
  input logic             sw_en,
  input logic [1:0]       mode
);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_wr |=> (cnt == $past(cnt)) || (cnt == $past(cnt) - CNT_W'(1)) ||
                 (cnt == $past(init_q)));

  // R4
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) && !init_wr |=> (cnt == '0));

  // R9
  deadline_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] && !init_wr |=> $stable(cnt));

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(expire));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(!mask && sw_en));

  // R8
  eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr && !expire |=> !irq_req);

endmodule

bind irq_countdown_timer itmr_chk #(.CNT_W(CNT_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .cnt     (cur_count),
  .init_q  (init_q),
  .init_wr (init_wr),
  .expire  (expire),
  .eoi_wr  (eoi_wr),
  .irq_req (irq_req),
  .mask    (ent.mask),
  .sw_en   (sw_en),
  .mode    (ent.mode)
);

// File: tb/irq_countdown_timer_tb_top.sv
module irq_countdown_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_req;
  logic [7:0]  irq_vector;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  irq_countdown_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_vector(irq_vector)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model state
  logic        m_en = 0, m_mask = 1, m_pend = 0;
  logic [7:0]  m_svec = 0, m_vec = 0, m_ivec = 0;
  int          m_mode = 0, m_div = 0, m_phase = 0;
  logic [31:0] m_init = 0, m_cnt = 0;

  function automatic int divisor(input int code);
    return (code == 7) ? 1 : (2 ** (code + 1));
  endfunction

  function automatic logic [31:0] mread(input logic [11:0] a);
    case (a)
      12'h0F0: return {23'd0, m_en, m_svec};
      12'h320: return {13'd0, m_mode[1:0], m_mask, 3'd0, m_pend, 4'd0, m_vec};
      12'h380: return m_init;
      12'h390: return m_cnt;
      12'h3E0: return 32'(m_div);
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    case (a)
      12'h320: return "R6 entry";
      12'h380: return "R2 init";
      12'h390: return "R3 current";
      12'h3E0: return "R3 divide";
      12'h0F0: return "R7 enable";
      default: return "R10 unmapped";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_mask = 1; m_pend = 0; m_svec = 0; m_vec = 0; m_ivec = 0;
      m_mode = 0; m_div = 0; m_phase = 0; m_init = 0; m_cnt = 0;
    end else begin
      bit wr, act, tk, ex;
      wr  = bus_valid && bus_write;
      act = (m_cnt != 0) && (m_mode < 2);
      tk  = act && (m_phase >= divisor(m_div) - 1);
      ex  = tk && (m_cnt == 1);
      if (wr && bus_addr == 12'h380) begin
        m_cnt = bus_wdata; m_phase = 0;
      end else begin
        if (tk) m_cnt = (m_cnt == 1) ? ((m_mode == 1) ? m_init : 0) : m_cnt - 1;
        if (act) m_phase = tk ? 0 : m_phase + 1;
      end
      if (ex && !m_mask && m_en) begin
        m_pend = 1; m_ivec = m_vec;
      end else if (wr && bus_addr == 12'h0B0) begin
        m_pend = 0;
      end
      if (wr) begin
        case (bus_addr)
          12'h0F0: begin m_en = bus_wdata[8]; m_svec = bus_wdata[7:0]; end
          12'h320: begin m_vec = bus_wdata[7:0]; m_mask = bus_wdata[16]; m_mode = int'(bus_wdata[18:17]); end
          12'h380: m_init = bus_wdata;
          12'h3E0: m_div = int'(bus_wdata[2:0]);
          default: ;
        endcase
      end
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R6 irq_req per-cycle", 32'(irq_req), 32'(m_pend));
      chk("R6 irq_vector per-cycle", 32'(irq_vector), 32'(m_ivec));
      chk(tag_of(bus_addr), bus_rdata, mread(bus_addr));
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic measure(input int exp, input string tag);
    int n = 0;
    do begin
      @(posedge clk); #2; n++;
    end while (!irq_req && n < 2000);
    chk(tag, 32'(n), 32'(exp));
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    rd(12'h320, 32'h0001_0000, "R1 entry reset");
    rd(12'h390, 0, "R1 current reset");
    rd(12'h3E0, 0, "R1 divide reset");
    rd(12'h0F0, 0, "R1 enable reset");
    chk("R1 irq reset", 32'(irq_req), 0);

    // R3 / R6 one-shot, divide by 1
    wr(12'h0F0, 32'h1FF);
    rd(12'h0F0, 32'h1FF, "R7 enable readback");
    wr(12'h320, 32'h41);
    wr(12'h3E0, 7);
    rd(12'h3E0, 7, "R3 divide readback");
    wr(12'h380, 5);
    measure(5, "R3 div1 cycles to expiry");
    chk("R6 vector", 32'(irq_vector), 32'h41);
    rd(12'h320, 32'h1041, "R6 pending bit");
    cyc(5);
    rd(12'h390, 0, "R4 one-shot stays zero");
    wr(12'h0B0, 32'hDEAD_BEEF);
    chk("R8 eoi clears", 32'(irq_req), 0);
    rd(12'h320, 32'h41, "R8 pending bit cleared");

    // R3 divide by 16 and by 2
    wr(12'h3E0, 3);
    wr(12'h380, 3);
    measure(48, "R3 div16 cycles to expiry");
    wr(12'h0B0, 0);
    wr(12'h3E0, 0);
    wr(12'h380, 4);
    measure(8, "R3 div2 cycles to expiry");
    wr(12'h0B0, 0);

    // R5 periodic reload, R8 collision and no queueing
    wr(12'h3E0, 7);
    wr(12'h320, 32'h0002_0042);
    wr(12'h380, 4);
    measure(4, "R5 periodic first expiry");
    rd(12'h390, 4, "R5 reload on expiry");
    chk("R6 vector periodic", 32'(irq_vector), 32'h42);
    cyc(3);
    wr(12'h0B0, 0);
    chk("R8 expiry wins over eoi", 32'(irq_req), 1);
    cyc(6);
    wr(12'h380, 0);
    rd(12'h390, 0, "R2 zero write stops");
    wr(12'h0B0, 1);
    chk("R8 single eoi clears all", 32'(irq_req), 0);
    cyc(10);
    chk("R8 nothing queued", 32'(irq_req), 0);
    rd(12'h390, 0, "R2 stays stopped");

    // R2 reload mid-count
    wr(12'h380, 100);
    cyc(3);
    wr(12'h380, 50);
    rd(12'h390, 50, "R2 load mid-count");
    rd(12'h380, 50, "R2 init readback");
    wr(12'h380, 0);

    // R7 mask and disable
    wr(12'h320, 32'h0001_0043);
    wr(12'h380, 3);
    cyc(8);
    chk("R7 masked no irq", 32'(irq_req), 0);
    rd(12'h390, 0, "R7 masked still counts");
    wr(12'h0F0, 32'h0FF);
    wr(12'h320, 32'h44);
    wr(12'h380, 3);
    cyc(8);
    chk("R7 disabled no irq", 32'(irq_req), 0);
    rd(12'h390, 0, "R7 disabled still counts");
    wr(12'h0F0, 32'h1FF);

    // R9 deadline and reserved modes hold
    wr(12'h320, 32'h0004_0045);
    wr(12'h380, 7);
    cyc(20);
    rd(12'h390, 7, "R9 deadline holds");
    wr(12'h320, 32'h0006_0045);
    cyc(5);
    rd(12'h390, 7, "R9 mode 11 holds");
    rd(12'h320, 32'h0006_0045, "R9 mode readback");
    chk("R9 no irq", 32'(irq_req), 0);
    wr(12'h380, 0);

    // R10 read-only and reserved bits
    wr(12'h320, 32'hFFFF_FFFF);
    rd(12'h320, 32'h0007_00FF, "R10 entry reserved/pending bits");
    wr(12'h3E0, 32'hFFFF_FFFF);
    rd(12'h3E0, 7, "R10 divide unused bits");
    wr(12'h390, 123);
    rd(12'h390, 0, "R10 current read-only");
    wr(12'h380, 32'h1234_5678);
    wr(12'h390, 5);
    rd(12'h390, 32'h1234_5678, "R10 current write ignored");
    rd(12'h200, 0, "R10 unmapped reads zero");
    rd(12'h0B0, 0, "R10 eoi reads zero");
    wr(12'h380, 0);

    // R11 maximum count
    wr(12'h320, 32'h0001_0000);
    wr(12'h380, 32'hFFFF_FFFF);
    cyc(10);
    rd(12'h390, 32'hFFFF_FFF5, "R11 current after 10 ticks");
    chk("R11 elapsed ticks", 32'hFFFF_FFFF - bus_rdata, 10);
    rd(12'h380, 32'hFFFF_FFFF, "R11 init readback");
    wr(12'h380, 0);
    cyc(2);

    finish_run();
  end

endmodule